// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the Start condition that opens every transfer of an I2C master. Software writes a small command register. When the start-request bit (bit 0) is written as 1 while the block is idle, the block releases SDA and waits for its line synchronizers to settle. It then checks that both bus lines are high and times two baud periods with a reloadable down-counter. SDA is pulled low at the end of the first period, which forms the Start. The sequence ends after the second period, and SDA is left held low so that the first data bit can follow.

The block checks the bus twice for arbitration loss: once when the sequence begins and again during the first baud period. On either failure it aborts to idle and raises a bus-collision flag. While a sequence is running it refuses new commands, so nothing can be queued behind the Start. A transmit-buffer write in this window is dropped and raises a write-collision flag. All flags are sticky until software clears them.

Top module: `i2c_start_gen`

## Requirements
- R1: SDA and SCL pass through a SYNC_STAGES-deep (default 2) synchronizer. A command write with bit 0 set while idle sets `cmd_q[0]` and releases SDA. The line levels are then sampled SYNC_STAGES+1 clock edges after the write edge.
- R2: If both lines are high at that sample, the baud counter loads `reload` and counts down once per clock. A baud period therefore lasts reload+1 clocks.
- R3: When the first period expires with SDA and SCL both high, `sda_drive_low` and `start_seen` rise on edge reload+4 after the write edge (default sync depth). `reload`=0 gives periods of one clock.
- R4: One further baud period after SDA is pulled low, `done_irq` is set and `cmd_q[0]` clears. `sda_drive_low` stays asserted after completion.
- R5: If either line is low at the initial sample, the block sets `bcol_irq`, releases SDA, clears `cmd_q[0]` and returns to idle without pulling SDA low.
- R6: If SCL is seen low during the first baud period, the block aborts the same way as in R5, and SDA is never pulled low.
- R7: A buffer write while a sequence is active sets `wcol` and leaves `buf_q` unchanged. A buffer write while idle loads `buf_q`.
- R8: Command writes while a sequence is active are ignored. All `cmd_q` bits keep their values, apart from bit 0, which clears at the end. Command writes while idle load every bit, and a write with bit 0 clear starts nothing.
- R9: `start_seen`, `done_irq`, `bcol_irq` and `wcol` are sticky. Each clears only through its `flag_clr` bit: bit 0 clears `start_seen`, bit 1 `done_irq`, bit 2 `bcol_irq` and bit 3 `wcol`.
- R10: After reset all flags are 0, `sda_drive_low` is 0, and `cmd_q` and `buf_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | CMD_W (5) | Command write data, bit 0 requests a Start |
| cmd_q | output | CMD_W (5) | Command register contents |
| reload | input | RELOAD_W (7) | Baud counter reload value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W (8) | Transmit buffer write data |
| buf_q | output | DATA_W (8) | Transmit buffer contents |
| sda_in | input | 1 | SDA line level, asynchronous |
| scl_in | input | 1 | SCL line level, asynchronous |
| flag_clr | input | 4 | Per-flag clear strobes |
| sda_drive_low | output | 1 | Open-drain control, 1 pulls SDA low |
| start_seen | output | 1 | Start condition generated (sticky) |
| done_irq | output | 1 | Start sequence complete (sticky) |
| bcol_irq | output | 1 | Bus collision abort (sticky) |
| wcol | output | 1 | Buffer write refused during a Start (sticky) |

## Verification
The assertions assume that the bus lines reach the controller only through the synchronizer. They also assume that software never holds `cmd_wr` and `buf_wr` in a pattern that depends on internal state. A write is simply accepted or refused according to whether a sequence is active. The bench models SDA as an open-drain wire, pulling it low whenever `sda_drive_low` is set, and changes the external line levels only on falling clock edges and only between or at planned points of a sequence. This keeps every collision at a known edge. Reload values stay small, so each run of the baud counter is short.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_HOLD1 = 2'd2,
      ST_HOLD2 = 2'd3
   } st_e;

   localparam int NFLAGS   = 4;
   localparam int FL_START = 0;
   localparam int FL_DONE  = 1;
   localparam int FL_BCOL  = 2;
   localparam int FL_WCOL  = 3;
endpackage

// File: rtl/i2c_start_sync.sv
module i2c_start_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_start_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end
endmodule

// File: rtl/i2c_start_brg.sv
module i2c_start_brg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         tmo
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign tmo = run && (cnt == '0);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
   import i2c_start_pkg::*;
#(
   parameter int RELOAD_W    = 7,
   parameter int CMD_W       = 5,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_wr,
   input  logic [CMD_W-1:0]    cmd_wdata,
   output logic [CMD_W-1:0]    cmd_q,
   input  logic [RELOAD_W-1:0] reload,
   input  logic                buf_wr,
   input  logic [DATA_W-1:0]   buf_wdata,
   output logic [DATA_W-1:0]   buf_q,
   input  logic                sda_in,
   input  logic                scl_in,
   input  logic [NFLAGS-1:0]   flag_clr,
   output logic                sda_drive_low,
   output logic                start_seen,
   output logic                done_irq,
   output logic                bcol_irq,
   output logic                wcol
);
   localparam int SETTLE   = SYNC_STAGES;
   localparam int SETTLE_W = $clog2(SETTLE + 1);

   if (RELOAD_W < 1 || RELOAD_W > 16) begin : g_bad_reload
      $error("i2c_start_gen: RELOAD_W out of range 1..16");
   end
   if (CMD_W < 1) begin : g_bad_cmd
      $error("i2c_start_gen: CMD_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("i2c_start_gen: DATA_W must be at least 1");
   end

   // line synchronizers: bit 1 = SDA, bit 0 = SCL
   logic [1:0] lines_s;
   logic       sda_s, scl_s;

   i2c_start_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sda_in, scl_in}),
      .q     (lines_s)
   );
   assign sda_s = lines_s[1];
   assign scl_s = lines_s[0];

   st_e                 state;
   logic [SETTLE_W-1:0] settle;
   logic                drv;
   logic [NFLAGS-1:0]   flags, flag_set;
   logic                busy, start_go;
   logic                arm_ok, drive_now, done_now, abort_now;
   logic                brg_load, brg_run, brg_tmo;

   i2c_start_brg #(.W(RELOAD_W)) u_brg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (brg_load),
      .load_val (reload),
      .run      (brg_run),
      .tmo      (brg_tmo)
   );

   assign busy     = (state != ST_IDLE);
   assign start_go = cmd_wr && !busy && cmd_wdata[0];

   always_comb begin
      arm_ok    = 1'b0;
      drive_now = 1'b0;
      done_now  = 1'b0;
      abort_now = 1'b0;
      unique case (state)
         ST_ARM: begin
            if (settle == '0) begin
               if (sda_s && scl_s) arm_ok    = 1'b1;
               else                abort_now = 1'b1;
            end
         end
         ST_HOLD1: begin
            if (!scl_s)               abort_now = 1'b1;
            else if (brg_tmo) begin
               if (sda_s)             drive_now = 1'b1;
               else                   abort_now = 1'b1;
            end
         end
         ST_HOLD2: done_now = brg_tmo;
         default: ;
      endcase
   end

   assign brg_load = arm_ok || drive_now;
   assign brg_run  = (state == ST_HOLD1) || (state == ST_HOLD2);

   always_comb begin
      flag_set           = '0;
      flag_set[FL_START] = drive_now;
      flag_set[FL_DONE]  = done_now;
      flag_set[FL_BCOL]  = abort_now;
      flag_set[FL_WCOL]  = buf_wr && busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         settle <= '0;
         drv    <= 1'b0;
         cmd_q  <= '0;
         buf_q  <= '0;
         flags  <= '0;
      end else begin
         flags <= (flags & ~flag_clr) | flag_set;
         if (buf_wr && !busy) buf_q <= buf_wdata;
         if (cmd_wr && !busy) cmd_q <= cmd_wdata;
         else if (done_now || abort_now) cmd_q[0] <= 1'b0;

         unique case (state)
            ST_IDLE: begin
               if (start_go) begin
                  state  <= ST_ARM;
                  settle <= SETTLE_W'(SETTLE);
                  drv    <= 1'b0;
               end
            end
            ST_ARM: begin
               if (settle != '0) settle <= settle - 1'b1;
               else if (arm_ok)  state  <= ST_HOLD1;
            end
            ST_HOLD1: begin
               if (drive_now) begin
                  state <= ST_HOLD2;
                  drv   <= 1'b1;
               end
            end
            ST_HOLD2: begin
               if (done_now) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase

         if (abort_now) begin
            state <= ST_IDLE;
            drv   <= 1'b0;
         end
      end
   end

   assign sda_drive_low = drv;
   assign start_seen    = flags[FL_START];
   assign done_irq      = flags[FL_DONE];
   assign bcol_irq      = flags[FL_BCOL];
   assign wcol          = flags[FL_WCOL];
endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk #(
   parameter int CMD_W  = 5,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              sda_s,
   input logic              scl_s,
   input logic              buf_wr,
   input logic [DATA_W-1:0] buf_q,
   input logic [CMD_W-1:0]  cmd_q,
   input logic              sda_drive_low,
   input logic              start_seen,
   input logic              done_irq,
   input logic              bcol_irq,
   input logic              wcol
);
   // R3: SDA is pulled low only when both synchronized lines were high
   a_r3_drive_on_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> ($past(sda_s) && $past(scl_s)));

   // R3: the Start flag appears together with SDA held low
   a_r3_start_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_seen) |-> sda_drive_low);

   // R4: completion clears the request bit and keeps SDA low
   a_r4_done_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_irq) |-> (!cmd_q[0] && sda_drive_low && !busy));

   // R5/R6: an abort releases SDA and clears the request bit
   a_r5_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bcol_irq) |-> (!sda_drive_low && !cmd_q[0] && !busy));

   // R7: buffer write during a sequence flags and leaves buffer alone
   a_r7_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && buf_wr) |=> (wcol && $stable(buf_q)));

   // R8: upper command bits cannot change while a sequence runs
   a_r8_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q[CMD_W-1:1]));
endmodule

bind i2c_start_gen i2c_start_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .sda_s         (sda_s),
   .scl_s         (scl_s),
   .buf_wr        (buf_wr),
   .buf_q         (buf_q),
   .cmd_q         (cmd_q),
   .sda_drive_low (sda_drive_low),
   .start_seen    (start_seen),
   .done_irq      (done_irq),
   .bcol_irq      (bcol_irq),
   .wcol          (wcol)
);

// File: tb/tb_i2c_start_gen.sv
`timescale 1ns/1ps
module tb_i2c_start_gen;
   localparam int KIND_DRIVE = 0;
   localparam int KIND_DONE  = 1;
   localparam int KIND_BCOL  = 2;

   typedef struct {
      int kind;
      int cyc;
      string tag;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [4:0] cmd_wdata = '0;
   logic [4:0] cmd_q;
   logic [6:0] reload = '0;
   logic       buf_wr = 1'b0;
   logic [7:0] buf_wdata = '0;
   logic [7:0] buf_q;
   logic       sda_ext = 1'b1;
   logic       scl_ext = 1'b1;
   logic       sda_in, scl_in;
   logic [3:0] flag_clr = '0;
   logic       sda_drive_low, start_seen, done_irq, bcol_irq, wcol;

   int   cyc = 0;
   int   errors = 0;
   int   checks = 0;
   ev_t  expq[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   assign sda_in = sda_ext & ~sda_drive_low;
   assign scl_in = scl_ext;

   i2c_start_gen dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_q(cmd_q), .reload(reload), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
      .buf_q(buf_q), .sda_in(sda_in), .scl_in(scl_in), .flag_clr(flag_clr),
      .sda_drive_low(sda_drive_low), .start_seen(start_seen),
      .done_irq(done_irq), .bcol_irq(bcol_irq), .wcol(wcol)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int kind, input int at, input string tag);
      ev_t e;
      e.kind = kind; e.cyc = at; e.tag = tag;
      expq.push_back(e);
   endtask

   // issue a start request on the next edge; returns the cycle stamp t0
   task automatic do_start(input int r, output int t0);
      reload    = 7'(r);
      cmd_wdata = 5'b00001;
      cmd_wr    = 1'b1;
      t0        = cyc;
      @(negedge clk);
      cmd_wr    = 1'b0;
   endtask

   task automatic clear_all();
      flag_clr = 4'b1111;
      @(negedge clk);
      flag_clr = 4'b0000;
   endtask

   // monitor: pops expected events as rising outputs appear
   logic p_drv = 1'b0, p_done = 1'b0, p_bcol = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_drive_low && !p_drv)  pop_cmp(KIND_DRIVE);
         if (done_irq && !p_done)      pop_cmp(KIND_DONE);
         if (bcol_irq && !p_bcol)      pop_cmp(KIND_BCOL);
      end
      p_drv  = sda_drive_low;
      p_done = done_irq;
      p_bcol = bcol_irq;
   end

   task automatic pop_cmp(input int kind);
      ev_t e;
      if (expq.size() == 0) begin
         chk(1'b0, "unexpected event", kind, -1);
      end else begin
         e = expq.pop_front();
         chk(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
         chk(e.cyc == cyc,   {e.tag, " cycle"}, cyc, e.cyc);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk({sda_drive_low, start_seen, done_irq, bcol_irq, wcol} == 5'b0, "R10 flags", 
          int'({sda_drive_low, start_seen, done_irq, bcol_irq, wcol}), 0);
      chk(cmd_q == 5'b0 && buf_q == 8'h0, "R10 regs", int'({cmd_q, buf_q}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: idle buffer write loads
      buf_wdata = 8'h5A; buf_wr = 1'b1;
      @(negedge clk);
      buf_wr = 1'b0;
      chk(buf_q == 8'h5A && !wcol, "R7 idle buffer load", int'(buf_q), 8'h5A);

      // Test A: reload 3, clean bus
      do_start(3, t0);                       // now cyc = t0+1
      push(KIND_DRIVE, t0 + 3 + 5, "R3 drive r=3");
      push(KIND_DONE,  t0 + 2*3 + 6, "R4 done r=3");
      chk(cmd_q[0] == 1'b1, "R1 request bit set", int'(cmd_q), 1);
      buf_wdata = 8'hC3; buf_wr = 1'b1;
      @(negedge clk);
      buf_wr = 1'b0;
      chk(wcol == 1'b1, "R7 wcol during start", int'(wcol), 1);
      chk(buf_q == 8'h5A, "R7 buffer unchanged", int'(buf_q), 8'h5A);
      cmd_wdata = 5'b11110; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(cmd_q == 5'b00001, "R8 command ignored while busy", int'(cmd_q), 1);
      repeat (15) @(negedge clk);
      chk(cmd_q == 5'b00000, "R4 request bit cleared", int'(cmd_q), 0);
      chk(sda_drive_low == 1'b1, "R4 SDA held low", int'(sda_drive_low), 1);
      chk(start_seen && done_irq && wcol, "R9 flags sticky",
          int'({start_seen, done_irq, wcol}), 7);
      flag_clr = 4'b0010;
      @(negedge clk);
      flag_clr = 4'b0000;
      chk(!done_irq && start_seen && wcol, "R9 clear done only",
          int'({start_seen, done_irq, wcol}), 5);
      clear_all();
      chk(!start_seen && !wcol, "R9 clear all", int'({start_seen, wcol}), 0);

      // Test B: reload 0, one-clock periods
      do_start(0, t0);
      push(KIND_DRIVE, t0 + 5, "R3 drive r=0");
      push(KIND_DONE,  t0 + 6, "R2 done r=0");
      repeat (10) @(negedge clk);
      chk(start_seen && done_irq, "R3 r=0 flags", int'({start_seen, done_irq}), 3);
      clear_all();

      // Test C: SCL low before the start (R5)
      scl_ext = 1'b0;
      repeat (3) @(negedge clk);
      do_start(4, t0);
      push(KIND_BCOL, t0 + 4, "R5 early collision");
      repeat (6) @(negedge clk);
      chk(!sda_drive_low && !start_seen, "R5 SDA released", int'({sda_drive_low, start_seen}), 0);
      chk(cmd_q[0] == 1'b0, "R5 request cleared", int'(cmd_q), 0);
      scl_ext = 1'b1;
      repeat (3) @(negedge clk);
      clear_all();

      // Test D: SCL drops during first period (R6)
      do_start(5, t0);                       // cyc = t0+1
      @(negedge clk);                        // cyc = t0+2
      scl_ext = 1'b0;
      push(KIND_BCOL, t0 + 5, "R6 collision in period");
      repeat (12) @(negedge clk);
      chk(!sda_drive_low && !start_seen && !done_irq, "R6 no start",
          int'({sda_drive_low, start_seen, done_irq}), 0);
      chk(cmd_q[0] == 1'b0, "R6 request cleared", int'(cmd_q), 0);
      scl_ext = 1'b1;
      repeat (3) @(negedge clk);
      clear_all();

      // R8: idle write without request bit loads and starts nothing
      cmd_wdata = 5'b10100; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      repeat (10) @(negedge clk);
      chk(cmd_q == 5'b10100, "R8 idle command load", int'(cmd_q), 5'b10100);
      chk(!start_seen && !bcol_irq, "R8 no start on bit0=0", int'({start_seen, bcol_irq}), 0);

      chk(expq.size() == 0, "all expected events seen", expq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule